// File: doc/BRIEF.md
# Dual-Tone Bearing Envelope Synthesizer

This block produces the amplitude envelope of a rotating navigation beacon as a stream of 12-bit codes for a parallel DAC. Each sample is a mid-scale DC level plus a fundamental tone and a ninth-harmonic tone. Each tone has its own programmable depth and phase. Both tones come from one phase accumulator, measured in tenths of a degree of the fundamental cycle, so they stay harmonically locked. A sample-enable strobe paces the accumulator. A small write port loads the depths, the phases and the accumulator increment.

Two markers go with the samples. A main marker flags the positive-slope zero crossing of the fundamental. An auxiliary marker flags each positive-slope zero crossing of the harmonic. Downstream timing logic uses both to measure bearing. New depths and phases are held in a shadow set. They move to the live set only at a main crossing, so no output cycle is ever distorted partway through.

Top module: `env_synth`

## Requirements
- R1: After reset, dac_o is 2048, main_ref_o, aux_ref_o and cfg_err_o are 0, all depths, phases and the step are 0, and the accumulator is 0.
- R2: On the edge where sample_en_i is high, the accumulator acc becomes (acc + step) mod 3600. The same edge loads dac_o with 2048 + round(D1·20.48·sin(a1·0.1°)) + round(D2·20.48·sin(9·a2·0.1°)), within ±2 LSB and saturated to 0..4095. Here a1 = (acc + P1) mod 3600 and a2 = (acc mod 400 + P2) mod 400, both taken on the new acc, with the live settings D1, D2, P1 and P2. dac_o does not change while sample_en_i is low.
- R3: A write to address 0 carries D1 in wdata[5:0] and D2 in wdata[13:8]. Bits [7:6] and [15:14] must be zero. The write is accepted only if D1 ≤ 40, D2 ≤ 40 and D1 + D2 ≤ 40. Otherwise the shadow depths keep their previous values.
- R4: A write to address 1 carries P1 in wdata[11:0], and values above 3599 are rejected. A write to address 2 carries P2 in wdata[8:0], and values above 399 are rejected.
- R5: A write to address 3 sets the step from wdata[8:0]. Values above 399 are rejected. The new step applies from the next sample. A step of 0 freezes the output and produces no markers.
- R6: cfg_err_o becomes 1 on the cycle after a rejected write and 0 on the cycle after an accepted write. Otherwise it holds its value.
- R7: The shadow depths and phases become live only on a sample edge whose a1 wraps (new a1 < old a1). That crossing sample is still computed with the old settings.
- R8: main_ref_o is high for exactly the one cycle after a sample edge at which a1 wraps.
- R9: aux_ref_o is high for exactly the one cycle after a sample edge at which a2 wraps. When P1 mod 400 equals P2, both markers fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Advances the accumulator and loads a new sample |
| cfg_we_i | input | 1 | Write strobe for the configuration port |
| cfg_addr_i | input | 2 | 0 depths, 1 fundamental phase, 2 harmonic phase, 3 step |
| cfg_wdata_i | input | 16 | Write data |
| dac_o | output | 12 | Envelope code |
| main_ref_o | output | 1 | Fundamental positive-crossing marker |
| aux_ref_o | output | 1 | Harmonic positive-crossing marker |
| cfg_err_o | output | 1 | Last write was rejected |

## Verification
The main and auxiliary markers fire on the same sample whenever the fundamental phase, taken modulo 400, equals the harmonic phase. The bench sets both phases to zero with a step of 40. It walks the samples until the reference model predicts a fundamental wrap, then checks that both markers are high together in that cycle. The same crossing edge also moves pending settings into the live set. Every sample is compared with a model that applies the pending depths only after a crossing, so a mistimed update shows up as a wrong code on the following sample.

// File: rtl/env_synth_pkg.sv
package env_synth_pkg;
  localparam int DAC_W     = 12;
  localparam int PH_W      = 12;
  localparam int SUB_W     = 9;
  localparam int DEP_W     = 6;
  localparam int SIN_W     = 16;
  localparam int FULL_TURN = 3600;
  localparam int SUB_TURN  = 400;
  localparam int QUARTER   = FULL_TURN / 4;
  localparam int HALF      = FULL_TURN / 2;
  localparam int DEPTH_MAX = 40;
  localparam int DC_LEVEL  = 1 << (DAC_W - 1);
  localparam int GAIN_K    = 5243;   // 20.48 * 256
  localparam int GAIN_SH   = 23;     // Q15 sine + Q8 gain

  typedef struct packed {
    logic [DEP_W-1:0] d1;
    logic [DEP_W-1:0] d2;
    logic [PH_W-1:0]  p1;
    logic [SUB_W-1:0] p2;
  } env_cfg_t;

  // sin(q * 0.1 deg) in Q15, q in 0..900, fixed-point Taylor series
  function automatic logic [SIN_W-1:0] sin_q15(input int q);
    longint one, x, term, acc;
    one  = 64'sd268435456;
    x    = (longint'(q) * 64'sd843314857) / 64'sd1800;
    term = x;
    acc  = x;
    for (int k = 1; k <= 7; k++) begin
      term = (term * x) / one;
      term = (term * x) / one;
      term = -term / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    acc = (acc * 64'sd32768 + one / 2) / one;
    if (acc > 64'sd32768) acc = 64'sd32768;
    if (acc < 0) acc = 0;
    return SIN_W'(acc);
  endfunction
endpackage

// File: rtl/env_cfg.sv
module env_cfg
  import env_synth_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [15:0]      wdata_i,
  input  logic             load_i,
  output env_cfg_t         live_o,
  output logic [SUB_W-1:0] step_o,
  output logic             err_o
);
  env_cfg_t         shadow_q, live_q;
  logic [SUB_W-1:0] step_q;
  logic             err_q;
  logic             ok;
  logic [DEP_W:0]   dsum;

  always_comb begin
    dsum = {1'b0, wdata_i[5:0]} + {1'b0, wdata_i[13:8]};
    unique case (addr_i)
      2'd0:    ok = (wdata_i[7:6] == 2'b00) && (wdata_i[15:14] == 2'b00) &&
                    (wdata_i[5:0] <= DEP_W'(DEPTH_MAX)) &&
                    (wdata_i[13:8] <= DEP_W'(DEPTH_MAX)) &&
                    (dsum <= (DEP_W+1)'(DEPTH_MAX));
      2'd1:    ok = wdata_i[PH_W-1:0] < PH_W'(FULL_TURN);
      default: ok = wdata_i[SUB_W-1:0] < SUB_W'(SUB_TURN);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      live_q   <= '0;
      step_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (we_i) begin
        err_q <= !ok;
        if (ok) begin
          unique case (addr_i)
            2'd0: begin
              shadow_q.d1 <= wdata_i[5:0];
              shadow_q.d2 <= wdata_i[13:8];
            end
            2'd1:    shadow_q.p1 <= wdata_i[PH_W-1:0];
            2'd2:    shadow_q.p2 <= wdata_i[SUB_W-1:0];
            default: step_q      <= wdata_i[SUB_W-1:0];
          endcase
        end
      end
      // a write on the crossing edge lands in shadow; live takes the old shadow
      if (load_i) live_q <= shadow_q;
    end
  end

  assign live_o = live_q;
  assign step_o = step_q;
  assign err_o  = err_q;

  assert_reject_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ok) |=> ($stable(shadow_q) && $stable(step_q) && err_q));
  assert_depth_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (({1'b0, live_q.d1} + {1'b0, live_q.d2}) <= (DEP_W+1)'(DEPTH_MAX)));
  assert_live_only_at_cross_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(live_q));
endmodule

// File: rtl/env_phase.sv
module env_phase
  import env_synth_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_en_i,
  input  logic [SUB_W-1:0] step_i,
  input  logic [PH_W-1:0]  p1_i,
  input  logic [SUB_W-1:0] p2_i,
  output logic [PH_W-1:0]  ang1_o,
  output logic [SUB_W-1:0] ang2_o,
  output logic             cross1_o,
  output logic             cross2_o
);
  logic [PH_W-1:0]  acc_q, acc_nx, a1_cur;
  logic [SUB_W-1:0] sub_q, sub_nx, a2_cur;

  function automatic logic [PH_W-1:0] wrap_full(input logic [PH_W:0] v);
    return (v >= (PH_W+1)'(FULL_TURN)) ? PH_W'(v - (PH_W+1)'(FULL_TURN)) : PH_W'(v);
  endfunction

  function automatic logic [SUB_W-1:0] wrap_sub(input logic [SUB_W:0] v);
    return (v >= (SUB_W+1)'(SUB_TURN)) ? SUB_W'(v - (SUB_W+1)'(SUB_TURN)) : SUB_W'(v);
  endfunction

  always_comb begin
    acc_nx   = wrap_full({1'b0, acc_q} + (PH_W+1)'(step_i));
    sub_nx   = wrap_sub({1'b0, sub_q} + {1'b0, step_i});
    a1_cur   = wrap_full({1'b0, acc_q} + {1'b0, p1_i});
    ang1_o   = wrap_full({1'b0, acc_nx} + {1'b0, p1_i});
    a2_cur   = wrap_sub({1'b0, sub_q} + {1'b0, p2_i});
    ang2_o   = wrap_sub({1'b0, sub_nx} + {1'b0, p2_i});
    cross1_o = sample_en_i && (ang1_o < a1_cur);
    cross2_o = sample_en_i && (ang2_o < a2_cur);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sub_q <= '0;
    end else if (sample_en_i) begin
      acc_q <= acc_nx;
      sub_q <= sub_nx;
    end
  end

  assert_acc_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q < PH_W'(FULL_TURN)) && (sub_q < SUB_W'(SUB_TURN)));
  assert_sub_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(acc_q) % SUB_TURN) == 32'(sub_q));
  assert_frozen_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0) |-> (!cross1_o && !cross2_o));
endmodule

// File: rtl/env_sine_lut.sv
module env_sine_lut
  import env_synth_pkg::*;
(
  input  logic [PH_W-1:0]         ang_i,
  output logic signed [SIN_W:0]   sin_o
);
  logic [SIN_W-1:0] rom [0:QUARTER];
  logic [PH_W-1:0]  q;
  logic             neg;

  for (genvar gi = 0; gi <= QUARTER; gi++) begin : g_rom
    localparam logic [SIN_W-1:0] VAL = sin_q15(gi);
    assign rom[gi] = VAL;
  end

  // fold the angle into the first quadrant
  always_comb begin
    if (ang_i < PH_W'(QUARTER)) begin
      q = ang_i;                       neg = 1'b0;
    end else if (ang_i < PH_W'(HALF)) begin
      q = PH_W'(HALF) - ang_i;         neg = 1'b0;
    end else if (ang_i < PH_W'(HALF + QUARTER)) begin
      q = ang_i - PH_W'(HALF);         neg = 1'b1;
    end else begin
      q = PH_W'(FULL_TURN) - ang_i;    neg = 1'b1;
    end
    sin_o = neg ? -$signed({1'b0, rom[q]}) : $signed({1'b0, rom[q]});
  end

  assert_fold_range: assert property (@(ang_i) (q <= PH_W'(QUARTER)));
endmodule

// File: rtl/env_synth.sv
module env_synth
  import env_synth_pkg::*;
#(
  parameter int OUT_W = DAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_en_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [15:0]      cfg_wdata_i,
  output logic [OUT_W-1:0] dac_o,
  output logic             main_ref_o,
  output logic             aux_ref_o,
  output logic             cfg_err_o
);
  localparam int SUM_W = OUT_W + 3;
  localparam int PRD_W = SIN_W + 18;

  env_cfg_t            live;
  logic [SUB_W-1:0]    step;
  logic [PH_W-1:0]     ang1, ang_h;
  logic [SUB_W-1:0]    ang2;
  logic                cross1, cross2;
  logic signed [SIN_W:0] s1, s2;
  logic signed [12:0]  c1, c2;
  logic signed [SUM_W-1:0] tot;
  logic [OUT_W-1:0]    sat, dac_q;
  logic                main_q, aux_q;

  env_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .load_i(cross1), .live_o(live), .step_o(step), .err_o(cfg_err_o)
  );

  env_phase u_phase (
    .clk_i, .rst_ni, .sample_en_i, .step_i(step), .p1_i(live.p1), .p2_i(live.p2),
    .ang1_o(ang1), .ang2_o(ang2), .cross1_o(cross1), .cross2_o(cross2)
  );

  assign ang_h = PH_W'({3'b000, ang2} << 3) + PH_W'(ang2);   // nine times

  env_sine_lut u_lut1 (.ang_i(ang1),  .sin_o(s1));
  env_sine_lut u_lut2 (.ang_i(ang_h), .sin_o(s2));

  // depth percent -> counts, magnitude rounded half away from zero
  function automatic logic signed [12:0] scale(input logic signed [SIN_W:0] s,
                                               input logic [DEP_W-1:0] d);
    logic [SIN_W:0]   mag;
    logic [PRD_W-1:0] prod;
    logic [11:0]      r;
    mag  = s[SIN_W] ? (SIN_W+1)'(-s) : (SIN_W+1)'(s);
    prod = PRD_W'(mag) * PRD_W'(d) * PRD_W'(GAIN_K);
    r    = 12'((prod + (PRD_W'(1) << (GAIN_SH - 1))) >> GAIN_SH);
    return s[SIN_W] ? -$signed({1'b0, r}) : $signed({1'b0, r});
  endfunction

  always_comb begin
    c1  = scale(s1, live.d1);
    c2  = scale(s2, live.d2);
    tot = SUM_W'(DC_LEVEL) + SUM_W'(c1) + SUM_W'(c2);
    if (tot < 0)                             sat = '0;
    else if (tot > SUM_W'((1 << OUT_W) - 1)) sat = '1;
    else                                     sat = OUT_W'(tot);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q  <= OUT_W'(DC_LEVEL);
      main_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      main_q <= cross1;
      aux_q  <= cross2;
      if (sample_en_i) dac_q <= sat;
    end
  end

  assign dac_o      = dac_q;
  assign main_ref_o = main_q;
  assign aux_ref_o  = aux_q;

  assert_dac_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(dac_o));
  assert_main_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_ref_o |=> (!main_ref_o || $past(sample_en_i)));
  assert_aux_after_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> !aux_ref_o);
  assert_main_after_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> !main_ref_o);
endmodule

// File: tb/env_synth_tb.sv
module env_synth_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [11:0] dac_o;
  logic        main_ref_o, aux_ref_o, cfg_err_o;

  env_synth u_dut (.*);

  always #5 clk_i = ~clk_i;

  int  nchk = 0, nerr = 0;
  bit  done = 1'b0;
  int  acc_m = 0, step_m = 0;
  int  sd1 = 0, sd2 = 0, sp1 = 0, sp2 = 0;
  int  ad1 = 0, ad2 = 0, ap1 = 0, ap2 = 0;
  bit  err_m = 1'b0;
  int  both_hits = 0;

  // d1, d2, p1, p2, step, samples
  localparam int VEC [0:3][0:5] = '{
    '{40,  0,    0,   0, 123,  70},
    '{ 0, 40,  900,   0,  77, 110},
    '{20, 20, 1800, 200, 399,  30},
    '{13, 27, 3599, 399, 211,  50}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int model_dac(input int a1, input int a2, input int d1, input int d2);
    real pi = 3.14159265358979;
    int  v;
    v = 2048 + int'(d1 * 20.48 * $sin(a1 * pi / 1800.0))
             + int'(d2 * 20.48 * $sin(((9 * a2) % 3600) * pi / 1800.0));
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic do_sample();
    int nx, a1c, a1n, a2c, a2n, ev, diff;
    bit m1, m2;
    string tag;
    nx  = (acc_m + step_m) % 3600;
    a1c = (acc_m + ap1) % 3600;
    a1n = (nx + ap1) % 3600;
    a2c = (acc_m % 400 + ap2) % 400;
    a2n = (nx % 400 + ap2) % 400;
    m1  = a1n < a1c;
    m2  = a2n < a2c;
    ev  = model_dac(a1n, a2n, ad1, ad2);
    tag = (sd1 != ad1 || sd2 != ad2 || sp1 != ap1 || sp2 != ap2) ? "R7 dac (pending held)" : "R2 dac";
    @(negedge clk_i) sample_en_i = 1'b1;
    @(negedge clk_i) sample_en_i = 1'b0;
    diff = int'(dac_o) - ev;
    chk(diff >= -2 && diff <= 2, tag, int'(dac_o), ev);
    chk(main_ref_o == m1, "R8 main marker", int'(main_ref_o), int'(m1));
    chk(aux_ref_o == m2, "R9 aux marker", int'(aux_ref_o), int'(m2));
    if (m1 && m2 && main_ref_o && aux_ref_o) both_hits++;
    acc_m = nx;
    if (m1) begin ad1 = sd1; ad2 = sd2; ap1 = sp1; ap2 = sp2; end
    @(negedge clk_i);
    chk(main_ref_o == 1'b0 && aux_ref_o == 1'b0, "R8 one-cycle pulse",
        int'(main_ref_o) + int'(aux_ref_o), 0);
  endtask

  task automatic cfg_write(input int addr, input int data, input string req);
    bit ok;
    case (addr)
      0: ok = ((data & 16'hC0C0) == 0) && (data & 63) <= 40 && ((data >> 8) & 63) <= 40 &&
              ((data & 63) + ((data >> 8) & 63)) <= 40;
      1: ok = (data & 12'hFFF) < 3600;
      default: ok = (data & 9'h1FF) < 400;
    endcase
    if (ok) begin
      case (addr)
        0: begin sd1 = data & 63; sd2 = (data >> 8) & 63; end
        1: sp1 = data & 12'hFFF;
        2: sp2 = data & 9'h1FF;
        default: step_m = data & 9'h1FF;
      endcase
    end
    err_m = !ok;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 2'(addr); cfg_wdata_i = 16'(data);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk(cfg_err_o == err_m, req, int'(cfg_err_o), int'(err_m));
  endtask

  function automatic int dep_word(input int d1, input int d2);
    return (d2 << 8) | d1;
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dac_o == 12'd2048, "R1 reset dac", int'(dac_o), 2048);
    chk(!main_ref_o && !aux_ref_o, "R1 reset markers", int'(main_ref_o) + int'(aux_ref_o), 0);
    chk(!cfg_err_o, "R1 reset err", int'(cfg_err_o), 0);
    // step 0 from reset: frozen output, no markers
    do_sample();
    chk(dac_o == 12'd2048, "R5 step zero holds", int'(dac_o), 2048);

    // table walk
    for (int v = 0; v < 4; v++) begin
      cfg_write(0, dep_word(VEC[v][0], VEC[v][1]), "R3 depth accept / R6");
      cfg_write(1, VEC[v][2], "R4 p1 accept / R6");
      cfg_write(2, VEC[v][3], "R4 p2 accept / R6");
      cfg_write(3, VEC[v][4], "R5 step accept / R6");
      for (int s = 0; s < VEC[v][5]; s++) do_sample();
    end

    // rejected writes keep state, err set, then cleared
    cfg_write(0, dep_word(30, 11), "R3 sum over cap rejected");
    cfg_write(0, dep_word(41, 0), "R3 single over cap rejected");
    cfg_write(0, dep_word(10, 10) | 16'h0040, "R3 reserved bits rejected");
    cfg_write(1, 3600, "R4 p1 out of range rejected");
    cfg_write(2, 400, "R4 p2 out of range rejected");
    cfg_write(3, 400, "R5 step out of range rejected");
    for (int s = 0; s < 20; s++) do_sample();
    cfg_write(0, dep_word(5, 35), "R6 accepted write clears err");

    // pending depths held until next fundamental crossing
    cfg_write(3, 50, "R5 step accept");
    for (int s = 0; s < 80; s++) do_sample();
    cfg_write(0, dep_word(38, 2), "R7 pending write");
    for (int s = 0; s < 80; s++) do_sample();

    // coincident markers
    cfg_write(1, 0, "R4 p1 zero");
    cfg_write(2, 0, "R4 p2 zero");
    cfg_write(3, 40, "R5 step 40");
    both_hits = 0;
    for (int s = 0; s < 200; s++) do_sample();
    chk(both_hits >= 1, "R9 main and aux coincide", both_hits, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule